// File: doc/BRIEF.md
# Cluster Hub Transfer Interface

This block is the electrical side of one cluster hub on a broadcast-capable global network. Each hub owns a private 64-bit sending channel and listens to every other hub's channel, so nothing on the global medium is arbitrated. On the way out, the hub collects words from the 16 cores of its cluster and places at most one word per cycle on its own channel. Each word carries a message kind, a tag and a destination hub. A core whose destination hub has raised its backward flow-control bit is held back. The other cores keep going.

On the way in, the global medium is modelled as 64 independent sender lanes, and each lane has a small queue. The queues drain onto two 32-bit broadcast trees that reach every core in the cluster. Each received 64-bit word is split into two beats on one tree. The hub raises a per-lane flow-control bit back toward the sender when that lane's queue is close to full.

Core-side ingress and tree egress are valid/ready streams. A core holds valid, and keeps its data, kind, tag and destination stable, until the cycle in which its ready is high. The transfer happens in that cycle. A tree holds valid and its beat stable while ready is low. The global lanes carry no ready: a sender must not drive a lane whose flow-control bit is high.

Top module: `cluster_hub_xfer`

## Requirements
- R1: A core word accepted in a cycle (core_tx_valid and core_tx_ready both high) appears on link_tx_valid/data/kind/tag/dest in the next cycle. At most one core is granted per cycle, and link_tx_valid is low in a cycle that follows a cycle with no accepted word.
- R2: Among eligible requesting cores, the grant goes to the first one found scanning upward (with wrap) from a pointer. After a grant the pointer moves to the granted core's index plus one.
- R3: A core whose destination hub has its fc_in bit high is not granted in that cycle, while other eligible cores are still served.
- R4: Every lane whose link_rx_valid is high in a cycle has its word queued in that lane's 4-entry FIFO. Words from one lane leave in arrival order, and all 64 lanes may deliver in the same cycle.
- R5: fc_out[h] is high exactly while lane h's FIFO holds 3 or more words. The flag is updated in the cycle after the push or pop that changes the count.
- R6: Each received word leaves as two beats on one tree: bits 31:0 first with tree_first=1, then bits 63:32 with tree_first=0. tree_src (sending lane index), tree_kind and tree_tag hold the message's values on both beats.
- R7: The second beat is valid in the cycle right after the first beat is accepted. A message is never split across trees.
- R8: While tree_valid is high and tree_ready is low, that tree's beat, first flag and metadata stay unchanged.
- R9: A tree is free when idle or when its second beat is accepted in this cycle. Free trees, in index order, each take a message from the first non-empty lane found scanning upward (with wrap) from a shared pointer, skipping lanes already taken by a lower tree this cycle. The pointer moves past the last lane taken. The first beat is valid in the next cycle.
- R10: While reset (rst_n low) is held, link_tx_valid, tree_valid and fc_out are all low, and both scan pointers start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_tx_valid | input | 16 | Per-core outgoing word valid |
| core_tx_ready | output | 16 | Per-core grant, one-hot or zero |
| core_tx_data | input | 16x64 | Per-core outgoing word |
| core_tx_kind | input | 16x2 | Per-core message kind |
| core_tx_tag | input | 16x4 | Per-core message tag |
| core_tx_dest | input | 16x6 | Per-core destination hub |
| fc_in | input | 64 | Backward flow-control bit from each hub |
| link_tx_valid | output | 1 | Own channel carries a word |
| link_tx_data | output | 64 | Own channel word |
| link_tx_kind | output | 2 | Own channel message kind |
| link_tx_tag | output | 4 | Own channel message tag |
| link_tx_dest | output | 6 | Own channel destination hub |
| link_rx_valid | input | 64 | Per-lane arriving word valid |
| link_rx_data | input | 64x64 | Per-lane arriving word |
| link_rx_kind | input | 64x2 | Per-lane message kind |
| link_rx_tag | input | 64x4 | Per-lane message tag |
| fc_out | output | 64 | Per-lane backward flow-control bit |
| tree_valid | output | 2 | Per-tree beat valid |
| tree_ready | input | 2 | Per-tree beat ready |
| tree_data | output | 2x32 | Per-tree beat data |
| tree_first | output | 2 | High on the low-half beat |
| tree_src | output | 2x6 | Sending lane of the message |
| tree_kind | output | 2x2 | Message kind |
| tree_tag | output | 2x4 | Message tag |

## Verification
The assertions check several properties on every cycle. The core grant is one-hot or zero, and an accepted core word always produces a link word in the next cycle. No core is granted toward a throttled hub. A tree beat stays frozen under back-pressure, and a first beat is always followed at once by its second. A lane FIFO only reaches full after its flow-control bit was already high, and it is never pushed past full or popped while empty. Only the bench's reference model can show that the round-robin order is right on both sides, that the halves and metadata land on the right tree in the right order, that per-lane ordering holds when many lanes arrive at once, and that fc_out follows the exact occupancy.

// File: rtl/chub_pkg.sv
package chub_pkg;
  localparam int MSG_KIND_W = 2;
  localparam int MSG_TAG_W  = 4;

  typedef struct packed {
    logic [MSG_KIND_W-1:0] kind;
    logic [MSG_TAG_W-1:0]  tag;
  } msg_meta_t;
endpackage

// File: rtl/chub_rr_pick.sv
module chub_rr_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      automatic int k = int'(ptr) + i;
      if (k >= N) k = k - N;
      if (!any && req[k]) begin
        any    = 1'b1;
        gnt[k] = 1'b1;
        idx    = IW'(k);
      end
    end
  end
endmodule

// File: rtl/chub_lane_fifo.sv
module chub_lane_fifo #(
  parameter int W      = 70,
  parameter int DEPTH  = 4,
  parameter int THRESH = 3,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         nearly_full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full        = (count == CW'(DEPTH));
  assign empty       = (count == '0);
  assign nearly_full = (count >= CW'(THRESH));
  assign do_pop      = pop && !empty;
  assign do_push     = push && (!full || do_pop);
  assign pop_data    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);                                             // R5
  AST_FC_LEADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(nearly_full));                                 // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);                                                     // R9
endmodule

// File: rtl/chub_tree_port.sv
module chub_tree_port #(
  parameter int DATA_W = 64,
  parameter int SRC_W  = 6,
  parameter int META_W = 6,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [SRC_W-1:0]  load_src,
  input  logic [META_W-1:0] load_meta,
  output logic              free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_data,
  output logic              out_first,
  output logic [SRC_W-1:0]  out_src,
  output logic [META_W-1:0] out_meta
);
  logic              busy, beat_hi;
  logic [DATA_W-1:0] hold_data;
  logic [SRC_W-1:0]  hold_src;
  logic [META_W-1:0] hold_meta;

  assign free      = !busy || (beat_hi && out_ready);
  assign out_valid = busy;
  assign out_first = !beat_hi;
  assign out_data  = beat_hi ? hold_data[DATA_W-1:HALF_W] : hold_data[HALF_W-1:0];
  assign out_src   = hold_src;
  assign out_meta  = hold_meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat_hi <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      beat_hi <= 1'b0;
    end else if (free) begin
      busy    <= 1'b0;
      beat_hi <= 1'b0;
    end else if (out_ready) begin
      beat_hi <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      hold_data <= load_data;
      hold_src  <= load_src;
      hold_meta <= load_meta;
    end
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first) && $stable(out_meta))); // R8
  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_first) |=> (out_valid && !out_first && $stable(out_src)));                 // R7
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);                                                                                           // R9
endmodule

// File: rtl/cluster_hub_xfer.sv
module cluster_hub_xfer import chub_pkg::*; #(
  parameter int NUM_CORES  = 16,
  parameter int NUM_HUBS   = 64,
  parameter int NUM_TREES  = 2,
  parameter int WORD_W     = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int FC_THRESH  = 3,
  localparam int HUB_W     = $clog2(NUM_HUBS),
  localparam int CORE_W    = $clog2(NUM_CORES),
  localparam int TREE_W    = WORD_W / 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_CORES-1:0]                  core_tx_valid,
  output logic [NUM_CORES-1:0]                  core_tx_ready,
  input  logic [NUM_CORES-1:0][WORD_W-1:0]      core_tx_data,
  input  logic [NUM_CORES-1:0][MSG_KIND_W-1:0]  core_tx_kind,
  input  logic [NUM_CORES-1:0][MSG_TAG_W-1:0]   core_tx_tag,
  input  logic [NUM_CORES-1:0][HUB_W-1:0]       core_tx_dest,
  input  logic [NUM_HUBS-1:0]                   fc_in,
  output logic                                  link_tx_valid,
  output logic [WORD_W-1:0]                     link_tx_data,
  output logic [MSG_KIND_W-1:0]                 link_tx_kind,
  output logic [MSG_TAG_W-1:0]                  link_tx_tag,
  output logic [HUB_W-1:0]                      link_tx_dest,
  input  logic [NUM_HUBS-1:0]                   link_rx_valid,
  input  logic [NUM_HUBS-1:0][WORD_W-1:0]       link_rx_data,
  input  logic [NUM_HUBS-1:0][MSG_KIND_W-1:0]   link_rx_kind,
  input  logic [NUM_HUBS-1:0][MSG_TAG_W-1:0]    link_rx_tag,
  output logic [NUM_HUBS-1:0]                   fc_out,
  output logic [NUM_TREES-1:0]                  tree_valid,
  input  logic [NUM_TREES-1:0]                  tree_ready,
  output logic [NUM_TREES-1:0][TREE_W-1:0]      tree_data,
  output logic [NUM_TREES-1:0]                  tree_first,
  output logic [NUM_TREES-1:0][HUB_W-1:0]       tree_src,
  output logic [NUM_TREES-1:0][MSG_KIND_W-1:0]  tree_kind,
  output logic [NUM_TREES-1:0][MSG_TAG_W-1:0]   tree_tag
);
  localparam int META_W  = $bits(msg_meta_t);
  localparam int ENTRY_W = META_W + WORD_W;

  // ---------------- transmit: cores -> own channel ----------------
  logic [NUM_CORES-1:0] tx_elig;
  logic [CORE_W-1:0]    tx_ptr, tx_idx;
  logic                 tx_any;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_elig
    assign tx_elig[c] = core_tx_valid[c] && !fc_in[core_tx_dest[c]];
    AST_TX_FC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      core_tx_ready[c] |-> !fc_in[core_tx_dest[c]]);                     // R3
  end

  chub_rr_pick #(.N(NUM_CORES)) u_tx_pick (
    .req (tx_elig),
    .ptr (tx_ptr),
    .gnt (core_tx_ready),
    .idx (tx_idx),
    .any (tx_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_tx_valid <= 1'b0;
      tx_ptr        <= '0;
    end else begin
      link_tx_valid <= tx_any;
      if (tx_any) tx_ptr <= (tx_idx == CORE_W'(NUM_CORES - 1)) ? '0 : tx_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_any) begin
      link_tx_data <= core_tx_data[tx_idx];
      link_tx_kind <= core_tx_kind[tx_idx];
      link_tx_tag  <= core_tx_tag[tx_idx];
      link_tx_dest <= core_tx_dest[tx_idx];
    end
  end

  AST_TX_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_tx_ready));                                            // R1
  AST_TX_LINK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(core_tx_valid & core_tx_ready)) |=> link_tx_valid);               // R1
  AST_TX_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(core_tx_valid & core_tx_ready)) |=> !link_tx_valid);             // R1

  // ---------------- receive: lanes -> per-lane FIFOs ----------------
  logic [NUM_HUBS-1:0]              lane_empty, lane_pop;
  logic [NUM_HUBS-1:0][ENTRY_W-1:0] lane_head;

  for (genvar h = 0; h < NUM_HUBS; h++) begin : g_lane
    msg_meta_t in_meta;
    assign in_meta = '{kind: link_rx_kind[h], tag: link_rx_tag[h]};
    chub_lane_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH), .THRESH(FC_THRESH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (link_rx_valid[h]),
      .push_data   ({in_meta, link_rx_data[h]}),
      .pop         (lane_pop[h]),
      .pop_data    (lane_head[h]),
      .empty       (lane_empty[h]),
      .nearly_full (fc_out[h])
    );
  end

  // ---------------- lane selection onto trees ----------------
  logic [HUB_W-1:0]                  rx_ptr, rx_ptr_nxt;
  logic [NUM_TREES-1:0][NUM_HUBS-1:0] avail, t_req, t_gnt;
  logic [NUM_TREES-1:0][HUB_W-1:0]   t_idx;
  logic [NUM_TREES-1:0]              t_any, t_free;

  assign avail[0] = ~lane_empty;

  for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
    msg_meta_t out_meta;
    logic [ENTRY_W-1:0] head;

    assign t_req[t] = t_free[t] ? avail[t] : '0;

    chub_rr_pick #(.N(NUM_HUBS)) u_lane_pick (
      .req (t_req[t]),
      .ptr (rx_ptr),
      .gnt (t_gnt[t]),
      .idx (t_idx[t]),
      .any (t_any[t])
    );

    if (t < NUM_TREES - 1) begin : g_mask
      assign avail[t+1] = avail[t] & ~t_gnt[t];
    end

    assign head = lane_head[t_idx[t]];

    chub_tree_port #(.DATA_W(WORD_W), .SRC_W(HUB_W), .META_W(META_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (t_any[t]),
      .load_data (head[WORD_W-1:0]),
      .load_src  (t_idx[t]),
      .load_meta (head[ENTRY_W-1:WORD_W]),
      .free      (t_free[t]),
      .out_valid (tree_valid[t]),
      .out_ready (tree_ready[t]),
      .out_data  (tree_data[t]),
      .out_first (tree_first[t]),
      .out_src   (tree_src[t]),
      .out_meta  (out_meta)
    );

    assign tree_kind[t] = out_meta.kind;
    assign tree_tag[t]  = out_meta.tag;
  end

  always_comb begin
    lane_pop   = '0;
    rx_ptr_nxt = rx_ptr;
    for (int t = 0; t < NUM_TREES; t++) begin
      lane_pop = lane_pop | t_gnt[t];
      if (t_any[t]) rx_ptr_nxt = (t_idx[t] == HUB_W'(NUM_HUBS - 1)) ? '0 : t_idx[t] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_ptr <= '0;
    else        rx_ptr <= rx_ptr_nxt;
  end
endmodule

// File: tb/cluster_hub_xfer_tb.sv
`timescale 1ns/1ps
module cluster_hub_xfer_tb;
  localparam int NC = 16;
  localparam int NH = 64;
  localparam int NT = 2;
  localparam real CLK_PERIOD = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NC-1:0]        core_tx_valid, core_tx_ready;
  logic [NC-1:0][63:0]  core_tx_data;
  logic [NC-1:0][1:0]   core_tx_kind;
  logic [NC-1:0][3:0]   core_tx_tag;
  logic [NC-1:0][5:0]   core_tx_dest;
  logic [NH-1:0]        fc_in;
  logic                 link_tx_valid;
  logic [63:0]          link_tx_data;
  logic [1:0]           link_tx_kind;
  logic [3:0]           link_tx_tag;
  logic [5:0]           link_tx_dest;
  logic [NH-1:0]        link_rx_valid;
  logic [NH-1:0][63:0]  link_rx_data;
  logic [NH-1:0][1:0]   link_rx_kind;
  logic [NH-1:0][3:0]   link_rx_tag;
  logic [NH-1:0]        fc_out;
  logic [NT-1:0]        tree_valid, tree_ready, tree_first;
  logic [NT-1:0][31:0]  tree_data;
  logic [NT-1:0][5:0]   tree_src;
  logic [NT-1:0][1:0]   tree_kind;
  logic [NT-1:0][3:0]   tree_tag;

  cluster_hub_xfer u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
    .core_tx_data(core_tx_data), .core_tx_kind(core_tx_kind),
    .core_tx_tag(core_tx_tag), .core_tx_dest(core_tx_dest),
    .fc_in(fc_in),
    .link_tx_valid(link_tx_valid), .link_tx_data(link_tx_data),
    .link_tx_kind(link_tx_kind), .link_tx_tag(link_tx_tag), .link_tx_dest(link_tx_dest),
    .link_rx_valid(link_rx_valid), .link_rx_data(link_rx_data),
    .link_rx_kind(link_rx_kind), .link_rx_tag(link_rx_tag),
    .fc_out(fc_out),
    .tree_valid(tree_valid), .tree_ready(tree_ready), .tree_data(tree_data),
    .tree_first(tree_first), .tree_src(tree_src), .tree_kind(tree_kind), .tree_tag(tree_tag)
  );

  // ---------------- reference model state ----------------
  typedef struct {
    logic [63:0] d;
    logic [1:0]  k;
    logic [3:0]  g;
  } msg_t;

  msg_t        mq [NH][$];
  int          rx_ptr = 0;
  int          tx_ptr = 0;
  bit          tb_busy [NT];
  bit          tb_hi   [NT];
  msg_t        th      [NT];
  int          tsrc    [NT];
  bit          e_v = 1'b0;
  logic [63:0] e_d;
  logic [1:0]  e_k;
  logic [3:0]  e_g;
  logic [5:0]  e_dst;

  bit          pv   [NC];
  logic [63:0] pd   [NC];
  logic [1:0]  pk   [NC];
  logic [3:0]  pg   [NC];
  logic [5:0]  pdst [NC];

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  bit seen_fc = 0, seen_dual = 0, seen_stall = 0, seen_hold = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // registered outputs against model state (called away from the edge)
  task automatic compare_regs();
    chk(link_tx_valid == e_v, "R1", "link_tx_valid", 128'(link_tx_valid), 128'(e_v));
    if (e_v && link_tx_valid)
      chk({link_tx_data, link_tx_kind, link_tx_tag, link_tx_dest} == {e_d, e_k, e_g, e_dst},
          "R1", "link word", {link_tx_data, link_tx_kind, link_tx_tag, link_tx_dest},
          {e_d, e_k, e_g, e_dst});
    for (int t = 0; t < NT; t++) begin
      chk(tree_valid[t] == tb_busy[t], "R9", "tree_valid", 128'(tree_valid[t]), 128'(tb_busy[t]));
      if (tb_busy[t] && tree_valid[t]) begin
        logic [31:0] ed;
        ed = tb_hi[t] ? th[t].d[63:32] : th[t].d[31:0];
        chk({tree_data[t], tree_first[t], tree_src[t], tree_kind[t], tree_tag[t]} ==
            {ed, !tb_hi[t], 6'(tsrc[t]), th[t].k, th[t].g},
            "R6,R7,R8", "tree beat", {tree_data[t], tree_first[t], tree_src[t], tree_kind[t], tree_tag[t]},
            {ed, !tb_hi[t], 6'(tsrc[t]), th[t].k, th[t].g});
      end
    end
    begin
      logic [NH-1:0] efc;
      for (int h = 0; h < NH; h++) efc[h] = (mq[h].size() >= 3);
      if (|efc) seen_fc = 1;
      chk(fc_out == efc, "R5", "fc_out", 128'(fc_out), 128'(efc));
    end
  endtask

  // one model clock step using the inputs driven for this cycle
  task automatic model_step();
    int granted = -1;
    logic [NC-1:0] erdy = '0;
    bit taken [NH];
    int last = -1;
    int loads = 0;
    for (int i = 0; i < NC; i++) begin
      int c = (tx_ptr + i) % NC;
      if (granted < 0 && core_tx_valid[c] && !fc_in[core_tx_dest[c]]) granted = c;
    end
    if (granted >= 0) erdy[granted] = 1'b1;
    chk(core_tx_ready == erdy, "R2,R3", "core_tx_ready", 128'(core_tx_ready), 128'(erdy));
    if (granted >= 0)
      for (int c = 0; c < NC; c++)
        if (core_tx_valid[c] && fc_in[core_tx_dest[c]]) seen_stall = 1;
    e_v = (granted >= 0);
    if (e_v) begin
      e_d = pd[granted]; e_k = pk[granted]; e_g = pg[granted]; e_dst = pdst[granted];
      pv[granted] = 1'b0;
      tx_ptr = (granted + 1) % NC;
    end
    for (int h = 0; h < NH; h++) taken[h] = 1'b0;
    for (int t = 0; t < NT; t++) begin
      bit fr = !tb_busy[t] || (tb_hi[t] && tree_ready[t]);
      if (tb_busy[t] && !tree_ready[t]) seen_hold = 1;
      if (fr) begin
        int pick = -1;
        for (int i = 0; i < NH; i++) begin
          int h = (rx_ptr + i) % NH;
          if (pick < 0 && mq[h].size() > 0 && !taken[h]) pick = h;
        end
        if (pick >= 0) begin
          taken[pick] = 1'b1;
          th[t] = mq[pick].pop_front();
          tsrc[t] = pick;
          tb_busy[t] = 1'b1;
          tb_hi[t] = 1'b0;
          last = pick;
          loads++;
        end else begin
          tb_busy[t] = 1'b0;
          tb_hi[t] = 1'b0;
        end
      end else if (tb_busy[t] && !tb_hi[t] && tree_ready[t]) begin
        tb_hi[t] = 1'b1;
      end
    end
    if (last >= 0) rx_ptr = (last + 1) % NH;
    if (loads >= 2) seen_dual = 1;
    for (int h = 0; h < NH; h++)
      if (link_rx_valid[h]) begin
        msg_t m;
        m.d = link_rx_data[h]; m.k = link_rx_kind[h]; m.g = link_rx_tag[h];
        mq[h].push_back(m);
      end
  endtask

  // stimulus for one cycle, chosen from the phase and model state
  task automatic gen_stim(input int cyc);
    int p_core, p_rx, p_rdy;
    bit fc_mode, near_dst;
    p_core = 0; p_rx = 0; p_rdy = 100; fc_mode = 0; near_dst = 0;
    if (cyc < 200)       begin p_core = 50; end
    else if (cyc < 400)  begin p_core = 60; fc_mode = 1; near_dst = 1; end
    else if (cyc < 600)  begin p_core = 100; end
    else if (cyc < 1000) begin p_rx = 20; p_rdy = 70; end
    else if (cyc < 1100) begin p_rx = 90; p_rdy = 5; end
    else if (cyc < 1200) begin p_rx = 30; p_rdy = 100; end
    else if (cyc < 1500) begin p_core = 40; p_rx = 25; p_rdy = 60; fc_mode = 1; near_dst = 1; end
    for (int c = 0; c < NC; c++) begin
      if (!pv[c] && ($urandom % 100) < p_core) begin
        pv[c] = 1'b1;
        pd[c] = {$urandom, $urandom};
        pk[c] = 2'($urandom);
        pg[c] = 4'($urandom);
        pdst[c] = near_dst ? 6'($urandom % 4) : 6'($urandom);
      end
      core_tx_valid[c] = pv[c];
      core_tx_data[c]  = pd[c];
      core_tx_kind[c]  = pk[c];
      core_tx_tag[c]   = pg[c];
      core_tx_dest[c]  = pdst[c];
    end
    for (int h = 0; h < NH; h++) begin
      fc_in[h] = fc_mode && (h < 4) && (($urandom % 100) < 40);
      link_rx_valid[h] = (mq[h].size() < 3) && (($urandom % 100) < p_rx);
      link_rx_data[h]  = {$urandom, $urandom};
      link_rx_kind[h]  = 2'($urandom);
      link_rx_tag[h]   = 4'($urandom);
    end
    for (int t = 0; t < NT; t++) tree_ready[t] = ($urandom % 100) < p_rdy;
  endtask

  initial begin
    core_tx_valid = '0; core_tx_data = '0; core_tx_kind = '0; core_tx_tag = '0; core_tx_dest = '0;
    fc_in = '0; link_rx_valid = '0; link_rx_data = '0; link_rx_kind = '0; link_rx_tag = '0;
    tree_ready = '0;
    for (int c = 0; c < NC; c++) pv[c] = 1'b0;
    for (int t = 0; t < NT; t++) begin tb_busy[t] = 0; tb_hi[t] = 0; tsrc[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(link_tx_valid == 1'b0, "R10", "link_tx_valid in reset", 128'(link_tx_valid), 128'(0));
    chk(tree_valid == '0, "R10", "tree_valid in reset", 128'(tree_valid), 128'(0));
    chk(fc_out == '0, "R10", "fc_out in reset", 128'(fc_out), 128'(0));
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 1700; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        compare_regs();
      end
      gen_stim(cyc);
      #1;
      model_step();
    end
    @(negedge clk);
    compare_regs();
    chk(seen_fc, "R5", "lane reached flow-control level", 128'(seen_fc), 128'(1));
    chk(seen_dual, "R9", "both trees loaded in one cycle", 128'(seen_dual), 128'(1));
    chk(seen_stall, "R3", "throttled core bypassed", 128'(seen_stall), 128'(1));
    chk(seen_hold, "R8", "beat held under back-pressure", 128'(seen_hold), 128'(1));
    chk(e_v == 1'b0 && !tb_busy[0] && !tb_busy[1], "R4", "all traffic drained",
        128'({e_v, tb_busy[0], tb_busy[1]}), 128'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule